// File: doc/BRIEF.md
# Sample Delivery Cadence Generator

This block sits next to one stream of a link that runs at a fixed 48 kHz frame rate. Once per link frame it decides how many sample blocks the stream carries in that frame, so that every supported sample rate is delivered at its exact long-term rate without drift. A 4-bit rate code selects the rate. Rates derived from 48 kHz use short repeating patterns. Rates derived from 44.1 kHz use a fixed 13-group pattern whose period is 160 frames at the 44.1 kHz base.

The link controller pulses `frame_tick` once per frame. One cycle later the block presents `frame_vld` together with the block count for that frame. A `restart` flag marks the frame that opens a new cadence. Each stream gets its own instance, so every stream's cadence runs independently of the others.

Top module: `cadence_gen`

## Requirements
- R1: `frame_vld` is high exactly in the cycle after each cycle with `frame_tick` high. In all other cycles `frame_vld`, `blk_cnt` and `restart` are 0.
- R2: The low-rate codes repeat a per-frame pattern that starts with the first frame of the cadence. Code 0 (8 kHz) gives 1 then five 0s. Code 1 (12 kHz) gives 1 then three 0s. Code 2 (16 kHz) gives 1,0,0. Code 3 (32 kHz) gives 2,0,0.
- R3: Code 4 (48 kHz) gives 1 block every frame. Code 5 (96 kHz) gives 2 every frame. Code 6 (192 kHz) gives 4 every frame.
- R4: Code 9 (44.1 kHz) walks 13 groups. The run lengths, in order, are 12,11,11,12,11,11,12,11,11,12,11,11,11. Each group is that many 1-block frames followed by one empty frame, which gives exactly 147 non-empty frames in every 160 frames.
- R5: Code 10 (88.2 kHz) and code 11 (176.4 kHz) follow the R4 frame pattern, with 2 and 4 blocks per non-empty frame, for 294 and 588 blocks per 160 frames.
- R6: Code 8 (22.05 kHz) expands every R4 frame into two frames. A block frame becomes 1,0 and an empty frame becomes 0,0, for 147 blocks per 320 frames.
- R7: Code 7 (11.025 kHz) expands every R4 frame into four frames. A block frame becomes 1,0,0,0 and an empty frame becomes four 0s, for 147 blocks per 640 frames.
- R8: A change of `rate_sel` between frames, or in the cycle of a tick, makes the next frame the first frame of the new rate's cadence, and `restart` is 1 on that frame only.
- R9: While `rst` is high all outputs are 0. The first frame after reset is the first frame of the cadence and carries `restart` = 1.
- R10: Codes 12 to 15 give 0 blocks in every frame.
- R11: `blk_cnt` only ever takes the values 0, 1, 2 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse at each link frame |
| rate_sel | input | 4 | Rate code, see R2 to R10 |
| frame_vld | output | 1 | Frame result strobe, one cycle after the tick |
| blk_cnt | output | 3 | Sample blocks carried in this frame |
| restart | output | 1 | This frame opens a new cadence |

## Verification
If an internal position counter goes wrong, the cadence loses phase. A missed group wrap or a wrong slot bound shows up as an empty frame in the wrong place within the first group (at most 13 frames at 44.1 kHz). A long/short run mix-up changes the per-period total that the bench counts over 160, 320 or 640 frames. A stale position after a rate change or reset shows up on the very first frame, as a missing `restart` or a non-block frame where a block is expected.

// File: rtl/cadence_pkg.sv
package cadence_pkg;

    localparam int BLK_W      = 3;
    localparam int RATE_W     = 4;
    localparam int NGROUPS    = 13;
    localparam int LONG_RUN   = 12;
    localparam int SHORT_RUN  = 11;
    localparam int GRP_W      = $clog2(NGROUPS);
    localparam int SLOT_W     = $clog2(LONG_RUN + 1);
    localparam int SUB_W      = 2;
    localparam int PH_W       = 3;

    typedef enum logic [RATE_W-1:0] {
        RATE_8K     = 4'd0,
        RATE_12K    = 4'd1,
        RATE_16K    = 4'd2,
        RATE_32K    = 4'd3,
        RATE_48K    = 4'd4,
        RATE_96K    = 4'd5,
        RATE_192K   = 4'd6,
        RATE_11K025 = 4'd7,
        RATE_22K05  = 4'd8,
        RATE_44K1   = 4'd9,
        RATE_88K2   = 4'd10,
        RATE_176K4  = 4'd11
    } rate_e;

    typedef struct packed {
        logic              fam441;  // 1: 44.1 kHz family
        logic [PH_W-1:0]   period;  // frames per cycle (48 kHz family)
        logic [BLK_W-1:0]  mult;    // blocks in a non-empty frame
        logic [SUB_W-1:0]  xlast;   // frame expansion minus one (44.1 family)
    } rate_cfg_t;

    function automatic rate_cfg_t decode_rate(input logic [RATE_W-1:0] code);
        rate_cfg_t c;
        c = '{fam441: 1'b0, period: 3'd1, mult: 3'd0, xlast: 2'd0};
        case (code)
            RATE_8K:     begin c.period = 3'd6; c.mult = 3'd1; end
            RATE_12K:    begin c.period = 3'd4; c.mult = 3'd1; end
            RATE_16K:    begin c.period = 3'd3; c.mult = 3'd1; end
            RATE_32K:    begin c.period = 3'd3; c.mult = 3'd2; end
            RATE_48K:    c.mult = 3'd1;
            RATE_96K:    c.mult = 3'd2;
            RATE_192K:   c.mult = 3'd4;
            RATE_11K025: begin c.fam441 = 1'b1; c.mult = 3'd1; c.xlast = 2'd3; end
            RATE_22K05:  begin c.fam441 = 1'b1; c.mult = 3'd1; c.xlast = 2'd1; end
            RATE_44K1:   begin c.fam441 = 1'b1; c.mult = 3'd1; end
            RATE_88K2:   begin c.fam441 = 1'b1; c.mult = 3'd2; end
            RATE_176K4:  begin c.fam441 = 1'b1; c.mult = 3'd4; end
            default:     ;
        endcase
        return c;
    endfunction

    // Long runs open every third group except the closing one.
    function automatic logic [SLOT_W-1:0] run_len(input logic [GRP_W-1:0] g);
        if (g != GRP_W'(NGROUPS - 1) && (g % 3) == 0)
            return SLOT_W'(LONG_RUN);
        return SLOT_W'(SHORT_RUN);
    endfunction

endpackage

// File: rtl/cadence_fam48.sv
module cadence_fam48
    import cadence_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clr,
    input  logic [PH_W-1:0]  period,
    input  logic [BLK_W-1:0] mult,
    output logic [BLK_W-1:0] blocks
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] pos;
    logic [PH_W-1:0] nxt;

    always_comb begin
        pos    = clr ? '0 : phase_q;
        blocks = (pos == '0) ? mult : '0;
        nxt    = (pos + PH_W'(1) >= period) ? '0 : pos + PH_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (step) phase_q <= nxt;
    end

    a_r2_phase_bound: assert property (@(posedge clk) disable iff (rst)
        !clr |-> phase_q < period);

endmodule

// File: rtl/cadence_fam441.sv
module cadence_fam441
    import cadence_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clr,
    input  logic [SUB_W-1:0] xlast,
    input  logic [BLK_W-1:0] mult,
    output logic [BLK_W-1:0] blocks
);
    logic [GRP_W-1:0]  grp_q,  grp_p,  grp_n;
    logic [SLOT_W-1:0] slot_q, slot_p, slot_n;
    logic [SUB_W-1:0]  sub_q,  sub_p,  sub_n;
    logic [SLOT_W-1:0] run;

    always_comb begin
        grp_p  = clr ? '0 : grp_q;
        slot_p = clr ? '0 : slot_q;
        sub_p  = clr ? '0 : sub_q;
        run    = run_len(grp_p);
        blocks = (sub_p == '0 && slot_p < run) ? mult : '0;
        grp_n  = grp_p;
        slot_n = slot_p;
        sub_n  = sub_p + SUB_W'(1);
        if (sub_p == xlast) begin
            sub_n  = '0;
            slot_n = slot_p + SLOT_W'(1);
            if (slot_p == run) begin
                slot_n = '0;
                grp_n  = (grp_p == GRP_W'(NGROUPS - 1)) ? '0 : grp_p + GRP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q  <= '0;
            slot_q <= '0;
            sub_q  <= '0;
        end else if (step) begin
            grp_q  <= grp_n;
            slot_q <= slot_n;
            sub_q  <= sub_n;
        end
    end

    a_r4_group_bound: assert property (@(posedge clk) disable iff (rst)
        grp_q < GRP_W'(NGROUPS));
    a_r4_slot_bound: assert property (@(posedge clk) disable iff (rst)
        slot_q <= run_len(grp_q));
    a_r6_sub_bound: assert property (@(posedge clk) disable iff (rst)
        !clr |-> sub_q <= xlast);

endmodule

// File: rtl/cadence_gen.sv
module cadence_gen
    import cadence_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              frame_vld,
    output logic [BLK_W-1:0]  blk_cnt,
    output logic              restart
);
    rate_cfg_t         cfg;
    logic [RATE_W-1:0] cur_rate;
    logic              pend;
    logic              clr;
    logic [BLK_W-1:0]  b48;
    logic [BLK_W-1:0]  b441;
    logic [BLK_W-1:0]  sel_blocks;

    always_comb begin
        cfg        = decode_rate(rate_sel);
        clr        = pend || (rate_sel != cur_rate);
        sel_blocks = cfg.fam441 ? b441 : b48;
    end

    cadence_fam48 u_fam48 (
        .clk    (clk),
        .rst    (rst),
        .step   (frame_tick),
        .clr    (clr),
        .period (cfg.period),
        .mult   (cfg.mult),
        .blocks (b48)
    );

    cadence_fam441 u_fam441 (
        .clk    (clk),
        .rst    (rst),
        .step   (frame_tick),
        .clr    (clr),
        .xlast  (cfg.xlast),
        .mult   (cfg.mult),
        .blocks (b441)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_vld <= 1'b0;
            blk_cnt   <= '0;
            restart   <= 1'b0;
            pend      <= 1'b1;
            cur_rate  <= rate_sel;
        end else begin
            frame_vld <= frame_tick;
            blk_cnt   <= frame_tick ? sel_blocks : '0;
            restart   <= frame_tick && clr;
            cur_rate  <= rate_sel;
            if (frame_tick)                 pend <= 1'b0;
            else if (rate_sel != cur_rate)  pend <= 1'b1;
        end
    end

    a_r1_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> frame_vld);
    a_r1_quiet_between: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> (!frame_vld && blk_cnt == '0 && !restart));
    a_r8_restart_on_change: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && rate_sel != $past(rate_sel)) |=> restart);
    a_r10_unused_empty: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && rate_sel >= 4'd12) |=> blk_cnt == '0);
    a_r11_legal_count: assert property (@(posedge clk) disable iff (rst)
        $onehot0(blk_cnt));

endmodule

// File: tb/cadence_gen_test.sv
module cadence_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic [3:0] rate_sel = 4'd9;
    logic       frame_vld;
    logic [2:0] blk_cnt;
    logic       restart;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cadence_gen uut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .rate_sel(rate_sel),
        .frame_vld(frame_vld), .blk_cnt(blk_cnt), .restart(restart)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int run_of(input int g);
        return (g != 12 && g % 3 == 0) ? 12 : 11;
    endfunction

    function automatic string req_of(input int r);
        case (r)
            0, 1, 2, 3: return "R2";
            4, 5, 6:    return "R3";
            7:          return "R7";
            8:          return "R6";
            9:          return "R4";
            10, 11:     return "R5";
            default:    return "R10";
        endcase
    endfunction

    // frames per full cadence period
    function automatic int period_of(input int r);
        case (r)
            0: return 6;  1: return 4;  2: return 3;  3: return 3;
            7: return 640; 8: return 320; 9, 10, 11: return 160;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_blk(input int r, input int f);
        int x, m, slot, sub, sp;
        case (r)
            0: return (f % 6 == 0) ? 1 : 0;
            1: return (f % 4 == 0) ? 1 : 0;
            2: return (f % 3 == 0) ? 1 : 0;
            3: return (f % 3 == 0) ? 2 : 0;
            4: return 1;
            5: return 2;
            6: return 4;
            7, 8, 9, 10, 11: begin
                x = (r == 7) ? 4 : (r == 8) ? 2 : 1;
                m = (r == 10) ? 2 : (r == 11) ? 4 : 1;
                slot = f / x;
                sub  = f % x;
                sp   = slot % 160;
                for (int g = 0; g < 13; g++) begin
                    if (sp < run_of(g) + 1)
                        return (sp < run_of(g) && sub == 0) ? m : 0;
                    sp -= run_of(g) + 1;
                end
                return -1;
            end
            default: return 0;
        endcase
    endfunction

    task automatic do_frame(output int b, output int rs);
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        check("R1 strobe", int'(frame_vld), 1);
        b  = int'(blk_cnt);
        rs = int'(restart);
        @(negedge clk);
        check("R1 idle", int'(frame_vld) + int'(blk_cnt) + int'(restart), 0);
    endtask

    // change rate, run nframes from cadence start, return block total
    task automatic run_rate(input int r, input int nframes, output int total);
        int b, rs;
        total = 0;
        @(negedge clk) rate_sel = 4'(r);
        for (int f = 0; f < nframes; f++) begin
            do_frame(b, rs);
            check(req_of(r), b, exp_blk(r, f));
            check("R8 restart", rs, (f == 0) ? 1 : 0);
            check("R11 legal", int'(b == 0 || b == 1 || b == 2 || b == 4), 1);
            total += b;
        end
    endtask

    initial begin
        int tot, b, rs, nz;
        repeat (3) @(negedge clk);
        check("R9 reset vld", int'(frame_vld), 0);
        check("R9 reset blk", int'(blk_cnt), 0);
        check("R9 reset restart", int'(restart), 0);
        @(negedge clk) rst = 1'b0;

        // R9: first frame after reset opens the 44.1 cadence
        nz = 0;
        for (int f = 0; f < 160; f++) begin
            do_frame(b, rs);
            check("R9 first", rs, (f == 0) ? 1 : 0);
            check("R4", b, exp_blk(9, f));
            if (b != 0) nz++;
        end
        check("R4 147 of 160", nz, 147);

        // all rates over two full periods each, order mixes families
        begin
            int order[13] = '{0, 9, 1, 8, 2, 7, 3, 10, 4, 11, 5, 12, 6};
            for (int i = 0; i < 13; i++) begin
                int r, p;
                r = order[i];
                p = period_of(r);
                run_rate(r, 2 * p, tot);
                case (r)
                    0, 1, 2, 4, 7, 8, 9: check({req_of(r), " total"}, tot, 2 * exp_blk(r, 0) * ((r >= 7) ? 147 : 1));
                    3:  check("R2 total", tot, 4);
                    5:  check("R3 total", tot, 4);
                    6:  check("R3 total", tot, 8);
                    10: check("R5 total", tot, 588);
                    11: check("R5 total", tot, 1176);
                    default: check("R10 total", tot, 0);
                endcase
            end
        end

        // R8: interrupt 44.1 mid-group, switch away and back
        run_rate(9, 17, tot);
        run_rate(8, 5, tot);
        run_rate(9, 30, tot);

        // R8: rate change in the same cycle as the tick
        @(negedge clk) begin rate_sel = 4'd3; frame_tick = 1'b1; end
        @(negedge clk) frame_tick = 1'b0;
        check("R8 same-cycle restart", int'(restart), 1);
        check("R2 same-cycle first", int'(blk_cnt), 2);
        @(negedge clk);

        // R9: reset in mid-cadence
        run_rate(11, 7, tot);
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R9 in reset", int'(frame_vld) + int'(blk_cnt), 0);
        @(negedge clk) rst = 1'b0;
        for (int f = 0; f < 14; f++) begin
            do_frame(b, rs);
            check("R9 after reset", rs, (f == 0) ? 1 : 0);
            check("R5", b, exp_blk(11, f));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule